// File: doc/BRIEF.md
# Spin Sequence Generator with Readout Slots

This block produces, pulse by pulse, the spin state that a spin flipper should apply. Each assertion of the pulse-start strobe moves the generator one step along a fixed eight-entry spin pattern, 1,0,0,1,0,1,1,0, which repeats without end. The generator reports the spin value, whether the current slot carries a spin state, a readout-window flag and the current position in the cycle.

In extended mode a dead slot follows every pair of spin states, which stretches the cycle to twelve pulses: 1,0,X,0,1,X,0,1,X,1,0,X. Pulses that land in a dead slot are thrown away on purpose. The acquisition system uses that time to move its buffered data, at the cost of a third of the pulses. The mode input is only taken at cycle boundaries, so a sequence is never cut short or mixed.

Top module: `spin_seq_gen`

## Requirements
- R1: While `rst` is high on a clock edge, the position goes to 0, the active mode is loaded from `ext_mode`, `spin_state` becomes 1, `slot_valid` becomes 1 and `readout_win` becomes 0.
- R2: The position advances by one only on a clock edge where `pulse_start` is high. With `pulse_start` low, every output keeps its value.
- R3: In base mode (`ext_mode` = 0 when latched) positions run 0..7 and wrap to 0. The spin values at those positions are 1,0,0,1,0,1,1,0, and `slot_valid` stays 1.
- R4: In extended mode (`ext_mode` = 1 when latched) positions run 0..11 and wrap to 0. Positions 2, 5, 8 and 11 are dead slots, and the others give spin values 1,0,_,0,1,_,0,1,_,1,0,_.
- R5: In a dead slot `slot_valid` is 0, `readout_win` is 1 and `spin_state` keeps the value of the last valid slot.
- R6: In every non-dead slot `slot_valid` is 1 and `readout_win` is 0.
- R7: `ext_mode` is only sampled on the strobe that wraps the position to 0, or during reset. A change in the middle of a cycle has no effect until that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_start | input | 1 | One-cycle strobe marking the start of a beam pulse |
| ext_mode | input | 1 | 1 = extended cycle with dead slots, 0 = base eight-step cycle |
| spin_state | output | 1 | Spin value for the current pulse |
| slot_valid | output | 1 | Current slot carries a spin state |
| readout_win | output | 1 | Current slot is a dead slot, free for data transfer |
| seq_pos | output | 4 | Position within the current cycle |

## Verification
Every result is registered: a strobe, a mode latch or a reset seen at one rising edge shows up on all four outputs straight after that edge, with one cycle of latency. The bench drives its inputs at the falling edge and applies the same edge to its behavioural model right after the rising edge. It compares all outputs at the next falling edge, so each check samples the cycle in which the result is due. Cycles without a strobe are compared too, which shows that nothing moves between pulses.

// File: rtl/spinseq_pkg.sv
package spinseq_pkg;

    localparam int OCT_LEN = 8;
    localparam int GROUP   = 2;
    localparam int EXT_LEN = OCT_LEN + OCT_LEN / GROUP;
    localparam int POS_W   = $clog2(EXT_LEN);

    // bit i holds pattern entry i: 1,0,0,1,0,1,1,0
    localparam logic [OCT_LEN-1:0] OCTET = 8'b0110_1001;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic {
        MODE_BASE = 1'b0,
        MODE_EXT  = 1'b1
    } seq_mode_e;

    typedef struct packed {
        logic valid;
        logic spin;
    } slot_t;

    function automatic pos_t last_pos(seq_mode_e m);
        return (m == MODE_EXT) ? pos_t'(EXT_LEN - 1) : pos_t'(OCT_LEN - 1);
    endfunction

endpackage

// File: rtl/slot_decode.sv
module slot_decode
    import spinseq_pkg::*;
#(
    parameter logic [OCT_LEN-1:0] PATTERN = OCTET
) (
    input  pos_t      pos,
    input  seq_mode_e mode,
    output slot_t     slot
);
    localparam int OCT_W = $clog2(OCT_LEN);

    slot_t ext_tab [EXT_LEN];

    // Extended table: every (GROUP+1)th entry is a dead slot
    for (genvar e = 0; e < EXT_LEN; e++) begin : g_ext
        localparam int PH   = e % (GROUP + 1);
        localparam bit DEAD = (PH == GROUP);
        localparam int IDX  = DEAD ? 0 : (e / (GROUP + 1)) * GROUP + PH;
        assign ext_tab[e].valid = !DEAD;
        assign ext_tab[e].spin  = DEAD ? 1'b0 : PATTERN[IDX];
    end

    always_comb begin
        slot = '{valid: 1'b1, spin: PATTERN[pos[OCT_W-1:0]]};
        if (mode == MODE_EXT) begin
            if (int'(pos) < EXT_LEN) slot = ext_tab[pos];
            else                     slot = '{valid: 1'b0, spin: 1'b0};
        end
    end
endmodule

// File: rtl/seq_counter.sv
module seq_counter
    import spinseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pulse_start,
    input  seq_mode_e mode_req,
    output pos_t      pos,
    output seq_mode_e act_mode,
    output pos_t      pos_next,
    output seq_mode_e mode_next
);
    logic at_last;

    assign at_last = (pos == last_pos(act_mode));

    always_comb begin
        pos_next  = pos;
        mode_next = act_mode;
        if (pulse_start) begin
            if (at_last) begin
                pos_next  = '0;
                mode_next = mode_req;
            end else begin
                pos_next = pos + pos_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            act_mode <= mode_req;
        end else begin
            pos      <= pos_next;
            act_mode <= mode_next;
        end
    end

    assert_pos_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !pulse_start |=> $stable(pos) && $stable(act_mode));

    assert_pos_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse_start && pos != last_pos(act_mode)) |=> pos == $past(pos) + pos_t'(1));

    assert_pos_range_R4: assert property (@(posedge clk) disable iff (rst)
        pos <= last_pos(act_mode));

    assert_mode_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_mode) |-> pos == '0);
endmodule

// File: rtl/spin_hold.sv
module spin_hold
    import spinseq_pkg::*;
#(
    parameter logic RESET_SPIN = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pulse_start,
    input  slot_t next_slot,
    output logic  spin
);
    always_ff @(posedge clk) begin
        if (rst)                                spin <= RESET_SPIN;
        else if (pulse_start && next_slot.valid) spin <= next_slot.spin;
    end

    assert_spin_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !pulse_start |=> $stable(spin));
endmodule

// File: rtl/spin_seq_gen.sv
module spin_seq_gen
    import spinseq_pkg::*;
#(
    parameter logic [OCT_LEN-1:0] PATTERN = OCTET,
    localparam int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_start,
    input  logic          ext_mode,
    output logic          spin_state,
    output logic          slot_valid,
    output logic          readout_win,
    output logic [PW-1:0] seq_pos
);
    pos_t      pos, pos_next;
    seq_mode_e act_mode, mode_next, mode_req;
    slot_t     cur_slot, nxt_slot;

    assign mode_req = seq_mode_e'(ext_mode);

    seq_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .pulse_start (pulse_start),
        .mode_req    (mode_req),
        .pos         (pos),
        .act_mode    (act_mode),
        .pos_next    (pos_next),
        .mode_next   (mode_next)
    );

    slot_decode #(.PATTERN(PATTERN)) u_dec_cur (
        .pos  (pos),
        .mode (act_mode),
        .slot (cur_slot)
    );

    slot_decode #(.PATTERN(PATTERN)) u_dec_nxt (
        .pos  (pos_next),
        .mode (mode_next),
        .slot (nxt_slot)
    );

    spin_hold #(.RESET_SPIN(PATTERN[0])) u_spin (
        .clk         (clk),
        .rst         (rst),
        .pulse_start (pulse_start),
        .next_slot   (nxt_slot),
        .spin        (spin_state)
    );

    assign seq_pos     = pos;
    assign slot_valid  = cur_slot.valid;
    assign readout_win = !cur_slot.valid;

    assert_dead_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |-> $stable(spin_state));

    assert_base_full_R3: assert property (@(posedge clk) disable iff (rst)
        act_mode == MODE_BASE |-> slot_valid);

    assert_valid_spin_R6: assert property (@(posedge clk) disable iff (rst)
        slot_valid |-> spin_state == cur_slot.spin);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> seq_pos == '0 && slot_valid && spin_state == PATTERN[0]);
endmodule

// File: tb/sim_spin_seq_gen.sv
module sim_spin_seq_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_start = 1'b0;
    logic       ext_mode = 1'b0;
    logic       spin_state, slot_valid, readout_win;
    logic [3:0] seq_pos;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model
    int base_pat [8]  = '{1, 0, 0, 1, 0, 1, 1, 0};
    int ext_pat  [12] = '{1, 0, -1, 0, 1, -1, 0, 1, -1, 1, 0, -1};
    int mpos  = 0;
    int mmode = 0;
    int mspin = 1;
    string tag = "R1";

    always #10 clk = ~clk;

    spin_seq_gen u0 (
        .clk(clk), .rst(rst), .pulse_start(pulse_start), .ext_mode(ext_mode),
        .spin_state(spin_state), .slot_valid(slot_valid),
        .readout_win(readout_win), .seq_pos(seq_pos)
    );

    function automatic int entry(int p, int m);
        return (m != 0) ? ext_pat[p] : base_pat[p];
    endfunction

    task automatic model_edge(input bit r, input bit p, input bit m);
        int len;
        bit pending;
        len = (mmode != 0) ? 12 : 8;
        pending = (int'(m) != mmode);
        if (r) begin
            mpos = 0; mmode = m; mspin = 1; tag = "R1";
        end else if (!p) begin
            tag = "R2";
        end else begin
            if (mpos == len - 1) begin
                mpos = 0; mmode = m; pending = 0;
            end else begin
                mpos++;
            end
            if (entry(mpos, mmode) >= 0) mspin = entry(mpos, mmode);
            if (pending)                         tag = "R7";
            else if (entry(mpos, mmode) < 0)     tag = "R5";
            else if (mmode != 0)                 tag = "R4 R6";
            else                                 tag = "R3";
        end
    endtask

    task automatic compare();
        int  ev;
        bit  exp_valid;
        ev = entry(mpos, mmode);
        exp_valid = (ev >= 0);
        checks++;
        if (seq_pos !== 4'(mpos) || slot_valid !== exp_valid ||
            readout_win !== !exp_valid || spin_state !== 1'(mspin)) begin
            fails++;
            $display("FAIL %s: actual pos=%0d valid=%b rd=%b spin=%b expected pos=%0d valid=%b rd=%b spin=%0d",
                     tag, seq_pos, slot_valid, readout_win, spin_state,
                     mpos, exp_valid, !exp_valid, mspin);
        end
    endtask

    task automatic step(input bit r, input bit p, input bit m);
        rst = r; pulse_start = p; ext_mode = m;
        @(posedge clk);
        #1 model_edge(r, p, m);
        @(negedge clk);
        compare();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset in base mode
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        // R3, R2: base cycle with idle gaps
        for (int i = 0; i < 20; i++) begin
            step(0, 1, 0);
            step(0, 0, 0);
        end
        // R7: request extended mode mid-cycle, then R4 R5 R6 back-to-back
        for (int i = 0; i < 40; i++) step(0, 1, 1);
        // R7: drop back to base mid-cycle, sparse strobes
        for (int i = 0; i < 30; i++) step(0, (i % 3) != 0, 0);
        // R1: reset mid-sequence loading extended mode
        for (int i = 0; i < 2; i++) step(1, 0, 1);
        for (int i = 0; i < 26; i++) begin
            step(0, 1, 1);
            if (i % 4 == 2) step(0, 0, 1);
        end
        // R5: idle while sitting in a dead slot
        for (int i = 0; i < 3; i++) step(0, 0, 0);
        for (int i = 0; i < 14; i++) step(0, 1, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule